// File: doc/BRIEF.md
# Indirect Register Window with Shared Index Pointer

This block is the slave-side register front end of a network controller. Two internal register files sit behind a small I/O window: the control/status file and the bus-configuration file. Software first writes an index into a pointer port. It then reads or writes through one of two data ports. The CSR data port reaches the selected entry of the control/status file, and the BCR data port reaches the same index in the bus-configuration file. A single pointer serves both data ports, so one load of the pointer gives access to entry N of either file.

The window has two layouts, and a mode input picks between them. In word I/O mode the ports sit at 10h (CSR data), 12h (pointer) and 16h (BCR data). In doubleword I/O mode they sit at 10h, 14h and 1Ch. Any other offset is dead: a write to it is dropped and a read of it returns zero. Each file has 128 index slots of 16 bits, and only the first `CSR_IMPL` or `BCR_IMPL` of them hold a real register. Read data is combinational and is valid in the same cycle as the read strobe. A write takes effect at the next rising clock edge.

Top module: `ioreg_window`

## Requirements
- R1: After a synchronous active-low reset the pointer holds 0, and every implemented entry of both files holds 0000h.
- R2: A write to the pointer port stores bits 7:0 of the write data and discards bits 31:8. A read of the pointer port returns the stored index in bits 7:0, with bits 31:8 returned as zero.
- R3: With `dwio_mode` = 0, offset 10h is the CSR data port, 12h is the pointer port and 16h is the BCR data port.
- R4: With `dwio_mode` = 1, offset 10h is the CSR data port, 14h is the pointer port and 1Ch is the BCR data port.
- R5: One pointer value selects the entry for both data ports. After a single pointer load, the two data ports reach CSR N and BCR N without the pointer being written again.
- R6: The two files are separate. A write through one data port never changes the entry with the same index in the other file.
- R7: An index at or above the file's implemented count, including any index of 128 or more, is unimplemented in that file. A write to it is dropped, and a read of it returns 0. Index count-1 behaves as a normal register.
- R8: An access to any offset that is not a port in the current mode has no effect on the pointer or on either file, and a read of it returns 0. This includes the pointer and BCR offsets of the other mode.
- R9: A change of `dwio_mode` leaves the pointer value unchanged.
- R10: A data port write stores bits 15:0 of the write data. A data port read returns the entry in bits 15:0, with bits 31:16 returned as zero.
- R11: While `io_rd` is low, `io_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dwio_mode | input | 1 | 0 selects the word I/O layout, 1 selects the doubleword I/O layout |
| io_addr | input | ADDR_W (5) | I/O offset within the window |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, data returned in the same cycle |
| io_wdata | input | BUS_W (32) | Write data |
| io_rdata | output | BUS_W (32) | Read data, zero when not reading |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle, and that `dwio_mode` changes only on a cycle with no access. The block treats a cycle with both strobes high as a write, and the properties that relate read data to a port do not cover that case. The stimulus respects both assumptions. Every access raises exactly one strobe for one cycle. The mode is driven on the falling edge, together with the address, before the strobe is sampled, so a mode switch never happens during an access.

// File: rtl/ioreg_pkg.sv
// Package: shared port kinds and window offsets for the indirect register
// window. Assumes a window of at most 32 byte offsets.
package ioreg_pkg;

    // Which of the three ports (or none) an I/O offset hits.
    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_CSR  = 2'd1,
        PORT_PTR  = 2'd2,
        PORT_BCR  = 2'd3
    } port_e;

    // Offsets of each port in the two layouts.
    localparam int OFS_CSR_ANY = 'h10;
    localparam int OFS_PTR_W   = 'h12;
    localparam int OFS_PTR_DW  = 'h14;
    localparam int OFS_BCR_W   = 'h16;
    localparam int OFS_BCR_DW  = 'h1C;

    // Number of index slots in each register file.
    localparam int FILE_SLOTS = 128;

endpackage

// File: rtl/ioreg_decode.sv
// Module: ioreg_decode
// Maps an I/O offset to a port kind in the layout picked by dwio_mode.
// Assumes dwio_mode is stable while an access is in progress.
module ioreg_decode
    import ioreg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              dwio_mode,
    input  logic [ADDR_W-1:0] io_addr,
    output port_e             port
);

    localparam logic [ADDR_W-1:0] A_CSR    = ADDR_W'(OFS_CSR_ANY);
    localparam logic [ADDR_W-1:0] A_PTR_W  = ADDR_W'(OFS_PTR_W);
    localparam logic [ADDR_W-1:0] A_PTR_DW = ADDR_W'(OFS_PTR_DW);
    localparam logic [ADDR_W-1:0] A_BCR_W  = ADDR_W'(OFS_BCR_W);
    localparam logic [ADDR_W-1:0] A_BCR_DW = ADDR_W'(OFS_BCR_DW);

    logic [ADDR_W-1:0] ptr_ofs;
    logic [ADDR_W-1:0] bcr_ofs;

    // Purpose: choose the mode-dependent offsets.
    always_comb begin
        ptr_ofs = dwio_mode ? A_PTR_DW : A_PTR_W;
        bcr_ofs = dwio_mode ? A_BCR_DW : A_BCR_W;
    end

    // Purpose: classify the offset; anything unlisted is PORT_NONE.
    always_comb begin
        if (io_addr == A_CSR)        port = PORT_CSR;
        else if (io_addr == ptr_ofs) port = PORT_PTR;
        else if (io_addr == bcr_ofs) port = PORT_BCR;
        else                         port = PORT_NONE;
    end

endmodule

// File: rtl/ioreg_ptr.sv
// Module: ioreg_ptr
// Index pointer shared by both data ports. It keeps only the index bits of
// a write, so the reserved upper bits always read back as zero.
// Assumes a write is qualified by the caller's decode.
module ioreg_ptr #(
    parameter int BUS_W = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] wdata,
    output logic [IDX_W-1:0] idx
);

    // Purpose: hold the index; clear on reset, load on a pointer write.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (load) idx <= wdata[IDX_W-1:0];
    end

endmodule

// File: rtl/ioreg_file.sv
// Module: ioreg_file
// One register file addressed by the shared index. Only indices below IMPL
// hold storage. A write to any other index is dropped, and a read of one
// returns zero. Assumes IMPL is at least 1.
module ioreg_file
    import ioreg_pkg::*;
#(
    parameter int IMPL   = 64,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IMPL_N = (IMPL > FILE_SLOTS) ? FILE_SLOTS : IMPL;
    localparam int AW     = (IMPL_N > 1) ? $clog2(IMPL_N) : 1;

    logic [DATA_W-1:0] mem [IMPL_N];
    logic              hit;
    logic [AW-1:0]     ix;

    // Purpose: decide whether the index names a real register.
    always_comb begin
        hit = ({24'd0, idx} < 32'(IMPL_N));
        ix  = AW'(idx);
    end

    // Purpose: clear storage on reset; store an implemented-index write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < IMPL_N; i++) mem[i] <= '0;
        end else if (we && hit) begin
            mem[ix] <= wdata;
        end
    end

    // Purpose: return the entry, or zero for an unimplemented index.
    always_comb begin
        rdata = hit ? mem[ix] : '0;
    end

endmodule

// File: rtl/ioreg_window.sv
// Module: ioreg_window (top)
// Indirect register window: one pointer port and two data ports, with the
// layout picked by dwio_mode. Reads are combinational; writes land on the
// next rising edge. Assumes at most one strobe per cycle and a stable mode
// during an access.
module ioreg_window
    import ioreg_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int BUS_W    = 32,
    parameter int DATA_W   = 16,
    parameter int IDX_W    = 8,
    parameter int CSR_IMPL = 100,
    parameter int BCR_IMPL = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dwio_mode,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [BUS_W-1:0]  io_wdata,
    output logic [BUS_W-1:0]  io_rdata
);

    localparam int NFILE = 2;   // 0: control/status, 1: bus configuration

    port_e             port;
    logic [IDX_W-1:0]  ptr_q;
    logic [NFILE-1:0]  file_we;
    logic [DATA_W-1:0] file_rd [NFILE];

    ioreg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .dwio_mode (dwio_mode),
        .io_addr   (io_addr),
        .port      (port)
    );

    ioreg_ptr #(.BUS_W(BUS_W), .IDX_W(IDX_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (io_wr && (port == PORT_PTR)),
        .wdata (io_wdata),
        .idx   (ptr_q)
    );

    // Purpose: steer a data-port write to exactly one file.
    always_comb begin
        file_we[0] = io_wr && (port == PORT_CSR);
        file_we[1] = io_wr && (port == PORT_BCR);
    end

    for (genvar g = 0; g < NFILE; g++) begin : g_file
        localparam int IMPL_G = (g == 0) ? CSR_IMPL : BCR_IMPL;
        ioreg_file #(.IMPL(IMPL_G), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_file (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (file_we[g]),
            .idx   (ptr_q),
            .wdata (io_wdata[DATA_W-1:0]),
            .rdata (file_rd[g])
        );
    end

    // Purpose: return data for the port being read, zero-extended.
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            case (port)
                PORT_CSR: io_rdata = BUS_W'(file_rd[0]);
                PORT_BCR: io_rdata = BUS_W'(file_rd[1]);
                PORT_PTR: io_rdata = BUS_W'(ptr_q);
                default:  io_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ioreg_window_chk.sv
// Module: ioreg_window_chk
// Property checker for ioreg_window, attached with bind. It decodes the
// offsets on its own and watches the pointer held inside the top.
// Assumes one strobe per cycle and a mode held steady during an access.
module ioreg_window_chk #(
    parameter int ADDR_W   = 5,
    parameter int BUS_W    = 32,
    parameter int DATA_W   = 16,
    parameter int IDX_W    = 8,
    parameter int CSR_IMPL = 100,
    parameter int BCR_IMPL = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dwio_mode,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [BUS_W-1:0]  io_wdata,
    input logic [BUS_W-1:0]  io_rdata,
    input logic [IDX_W-1:0]  ptr_q
);

    logic at_csr, at_ptr, at_bcr;

    // Purpose: independent decode of the three port offsets.
    always_comb begin
        at_csr = (io_addr == ADDR_W'('h10));
        at_ptr = (io_addr == (dwio_mode ? ADDR_W'('h14) : ADDR_W'('h12)));
        at_bcr = (io_addr == (dwio_mode ? ADDR_W'('h1C) : ADDR_W'('h16)));
    end

    p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_ptr) |=> (ptr_q == $past(io_wdata[IDX_W-1:0])));

    p_ptr_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at_ptr) |-> (io_rdata[BUS_W-1:IDX_W] == '0));

    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && at_ptr) |=> $stable(ptr_q));

    p_data_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (at_csr || at_bcr)) |-> (io_rdata[BUS_W-1:DATA_W] == '0));

    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && !at_csr && !at_ptr && !at_bcr) |-> (io_rdata == '0));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == '0));

    p_unimpl_csr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && at_csr && (32'(ptr_q) >= 32'(CSR_IMPL))) |-> (io_rdata == '0));

    p_unimpl_bcr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && at_bcr && (32'(ptr_q) >= 32'(BCR_IMPL))) |-> (io_rdata == '0));

endmodule

bind ioreg_window ioreg_window_chk #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .CSR_IMPL(CSR_IMPL), .BCR_IMPL(BCR_IMPL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dwio_mode(dwio_mode), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ptr_q(ptr_q)
);

// File: tb/ioreg_window_tb.sv
// Bench for ioreg_window: a table of vectors walked by one loop, followed by
// directed tests for reset, mode switching, index limits and idle reads.
module ioreg_window_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dwio_mode = 1'b0;
    logic [4:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    ioreg_window u_dut (
        .clk(clk), .rst_n(rst_n), .dwio_mode(dwio_mode), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    typedef struct packed {
        logic        rd;
        logic        dw;
        logic [4:0]  addr;
        logic [31:0] data;   // write data, or expected read data
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 5'h12, 32'h0000_0004},  // R3 pointer load, word layout
        '{1'b0, 1'b0, 5'h10, 32'h0000_1234},  // R3 CSR4 write
        '{1'b0, 1'b0, 5'h16, 32'h0000_ABCD},  // R3 BCR4 write
        '{1'b1, 1'b0, 5'h10, 32'h0000_1234},  // R5 CSR4 read
        '{1'b1, 1'b0, 5'h16, 32'h0000_ABCD},  // R5 BCR4 read, no reload
        '{1'b1, 1'b0, 5'h12, 32'h0000_0004},  // R2 pointer read
        '{1'b0, 1'b0, 5'h12, 32'hFFFF_FF07},  // R2 reserved bits set
        '{1'b1, 1'b0, 5'h12, 32'h0000_0007},  // R2 only index kept
        '{1'b0, 1'b0, 5'h10, 32'hDEAD_5A5A},  // R10 CSR7 write, upper dropped
        '{1'b1, 1'b0, 5'h10, 32'h0000_5A5A},  // R10 low half stored
        '{1'b1, 1'b0, 5'h16, 32'h0000_0000},  // R6 BCR7 untouched
        '{1'b0, 1'b1, 5'h14, 32'h0000_0004},  // R4 pointer load, dword layout
        '{1'b1, 1'b1, 5'h10, 32'h0000_1234},  // R4 CSR4 read
        '{1'b1, 1'b1, 5'h1C, 32'h0000_ABCD},  // R4 BCR4 read
        '{1'b0, 1'b1, 5'h1C, 32'h0000_0042},  // R4 BCR4 write
        '{1'b1, 1'b1, 5'h1C, 32'h0000_0042},  // R4 BCR4 readback
        '{1'b1, 1'b1, 5'h10, 32'h0000_1234},  // R6 CSR4 untouched
        '{1'b0, 1'b1, 5'h12, 32'h0000_0009},  // R8 word pointer offset dead in dword
        '{1'b1, 1'b1, 5'h14, 32'h0000_0004},  // R8 pointer still 4
        '{1'b1, 1'b1, 5'h16, 32'h0000_0000},  // R8 word BCR offset reads 0
        '{1'b0, 1'b0, 5'h1C, 32'h0000_7777},  // R8 dword BCR offset dead in word
        '{1'b1, 1'b0, 5'h16, 32'h0000_0042}   // R8 BCR4 unchanged
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic dw, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        dwio_mode = dw; io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_rd(input string req, input logic dw, input logic [4:0] a,
                         input logic [31:0] exp);
        @(negedge clk);
        dwio_mode = dw; io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        #2;
        check(req, io_rdata, exp);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    initial begin : watchdog
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of the pointer and of both files.
        do_rd("R1", 1'b0, 5'h12, 32'h0);
        do_rd("R1", 1'b0, 5'h10, 32'h0);
        do_rd("R1", 1'b0, 5'h16, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) do_rd($sformatf("vec%0d", i), VECS[i].dw, VECS[i].addr, VECS[i].data);
            else            do_wr(VECS[i].dw, VECS[i].addr, VECS[i].data);
        end

        // R9: a mode change keeps the pointer.
        do_wr(1'b0, 5'h12, 32'h21);
        do_rd("R9", 1'b1, 5'h14, 32'h21);
        do_rd("R9", 1'b0, 5'h12, 32'h21);

        // R7: the last implemented index works, the first unimplemented one is dead.
        do_wr(1'b0, 5'h12, 32'd99);
        do_wr(1'b0, 5'h10, 32'h0000_0099);
        do_rd("R7", 1'b0, 5'h10, 32'h0000_0099);
        do_wr(1'b0, 5'h12, 32'd100);
        do_wr(1'b0, 5'h10, 32'h0000_1111);
        do_rd("R7", 1'b0, 5'h10, 32'h0);
        do_wr(1'b0, 5'h12, 32'd60);                // CSR60 real, BCR60 not
        do_wr(1'b0, 5'h10, 32'h0000_6060);
        do_wr(1'b0, 5'h16, 32'h0000_2222);
        do_rd("R7", 1'b0, 5'h10, 32'h0000_6060);
        do_rd("R7", 1'b0, 5'h16, 32'h0);
        do_wr(1'b0, 5'h12, 32'd49);
        do_wr(1'b0, 5'h16, 32'h0000_4949);
        do_rd("R7", 1'b0, 5'h16, 32'h0000_4949);
        do_wr(1'b0, 5'h12, 32'd200);
        do_wr(1'b0, 5'h10, 32'h0000_3333);
        do_rd("R7", 1'b0, 5'h10, 32'h0);
        do_wr(1'b0, 5'h12, 32'd72);                // 200 mod 128: no aliasing
        do_rd("R7", 1'b0, 5'h10, 32'h0);

        // R8: unmapped offsets read zero and leave the pointer alone.
        do_wr(1'b0, 5'h00, 32'h0000_0011);
        do_rd("R8", 1'b0, 5'h00, 32'h0);
        do_rd("R8", 1'b0, 5'h12, 32'd72);

        // R11: no read strobe means zero read data.
        @(negedge clk);
        io_addr = 5'h12; io_rd = 1'b0;
        #2;
        check("R11", io_rdata, 32'h0);

        // R1: a reset in mid-run clears the pointer and the files.
        do_wr(1'b0, 5'h12, 32'h4);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_rd("R1", 1'b0, 5'h12, 32'h0);
        do_wr(1'b0, 5'h12, 32'h4);
        do_rd("R1", 1'b0, 5'h10, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule